// File: doc/BRIEF.md
# Watchdog and Periodic Alarm Down-Counter

This block holds a 24-bit down-counter and a seed register behind a small byte-wide register port. In alarm mode the counter steps once per 1 Hz tick. Each time it runs out it raises a status flag, reloads itself from the seed and keeps going. In watchdog mode it steps on the 4096 Hz tick. When it runs out it raises the flag, stops, and emits a fixed-length active-low pulse. That pulse goes either to a reset request (register access is locked out during it) or to an interrupt request, depending on a steering bit.

Software keeps the watchdog from firing by touching any counter byte, which restarts the count from the seed. A write becomes effective only when the most significant byte arrives, so a half-written value is never used. Writing an all-zero value switches the counter off without raising the flag. With the enable bit low, the three bytes are simply storage. Each open-drain pin is presented as an active-low level plus a drive enable.

Top module: `wdalm_timer`

## Requirements
- R1: After synchronous reset the flag is 0, both pulse outputs are released (level 1, drive enable 0) and the read data is 0.
- R2: Byte index 0 is bits 7:0, index 1 is bits 15:8, index 2 is bits 23:16. Writes to indices 0 and 1 are only staged. A write to index 2 loads the live counter and the seed together with {index2, staged1, staged0}.
- R3: A read of index 0 returns bits 7:0 of the live count and captures the whole live count. Reads of indices 1 and 2 return the captured bytes. Read data appears in the cycle after the read strobe.
- R4: In alarm mode (mode bit 0), the counter steps only on 1 Hz ticks. When it reaches zero, the flag is set and the counter reloads from the seed and keeps counting. The flag-clear strobe clears the flag when no pulse is active.
- R5: In watchdog mode (mode bit 1), the counter steps only on 4096 Hz ticks. When it reaches zero, it sets the flag and stops at 0.
- R6: In watchdog mode with steer 0, expiry drives the reset request low for PULSE_TICKS 4096 Hz ticks, and register reads and writes are ignored during that time. When the pulse ends, the flag clears and the pin is released.
- R7: In watchdog mode with steer 1 and interrupt enable 1, expiry drives the interrupt request low for PULSE_TICKS ticks. Clearing the flag or the interrupt enable during the pulse does not shorten it. When the pulse ends, the flag clears.
- R8: A value written during an interrupt pulse is held unchanged until the pulse ends, and counting starts only after that.
- R9: Any accepted read or write of a counter byte reloads the counter from the seed and restarts it.
- R10: With the enable bit at 0, ticks never change the counter and never set the flag.
- R11: With the enable bit at 1, writing all 24 bits as zero leaves the counter idle, and the flag is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle 1 Hz step enable |
| tick_4khz | input | 1 | One-cycle 4096 Hz step enable |
| cfg_en | input | 1 | Counter enable |
| cfg_wdmode | input | 1 | 0 alarm mode, 1 watchdog mode |
| cfg_steer | input | 1 | Watchdog pulse target: 0 reset, 1 interrupt |
| cfg_irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Strobe that writes the flag to zero |
| reg_wr | input | 1 | Byte write strobe |
| reg_rd | input | 1 | Byte read strobe |
| reg_addr | input | 2 | Byte index 0..2 |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| flag_o | output | 1 | Alarm/watchdog flag |
| rst_n_o | output | 1 | Reset request level, active low |
| rst_oe_o | output | 1 | Reset request drive enable |
| irq_n_o | output | 1 | Interrupt request level, active low |
| irq_oe_o | output | 1 | Interrupt request drive enable |

## Verification
If the live count or the seed drifts, the next read shows the wrong value in the cycle after the strobe. A wrong count also moves flag expiry earlier or later by whole ticks, so the bench checks the flag on the exact tick where it must rise. If the pulse timer or the pulse kind is wrong, a drive enable drops one or more ticks early or late, or the wrong pin is driven; the bench checks the tick before and the tick at the end of each pulse. A lost staging byte or a missed access lockout only shows at the next read back, so every such case is followed at once by a full three-byte read.

// File: rtl/wdalm_pkg.sv
package wdalm_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    PK_NONE = 2'd0,
    PK_RST  = 2'd1,
    PK_IRQ  = 2'd2
  } pulse_kind_e;
endpackage

// File: rtl/wdalm_regport.sv
module wdalm_regport
  import wdalm_pkg::*;
#(
  parameter int CNT_W = 24,
  localparam int NBYTES = CNT_W / BYTE_W,
  localparam int AW = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              blocked,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [AW-1:0]     reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  input  logic [CNT_W-1:0]  live,
  output logic              access_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic [BYTE_W-1:0] rdata_o
);
  localparam int STG_W = CNT_W - BYTE_W;

  logic              in_range;
  logic              wr_ok, rd_ok;
  logic [STG_W-1:0]  stage_q;
  logic [CNT_W-1:0]  hold_q;
  logic [CNT_W-1:0]  src;

  assign in_range   = (reg_addr < AW'(NBYTES));
  assign wr_ok      = reg_wr && !blocked && in_range;
  assign rd_ok      = reg_rd && !reg_wr && !blocked && in_range;
  assign access_o   = wr_ok || rd_ok;
  assign load_o     = wr_ok && (reg_addr == AW'(NBYTES - 1));
  assign load_val_o = {reg_wdata, stage_q};
  assign src        = (reg_addr == '0) ? live : hold_q;

  // staging of the lower bytes; committed with the top byte
  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else if (wr_ok) begin
      for (int b = 0; b < NBYTES - 1; b++) begin
        if (reg_addr == AW'(b)) stage_q[b*BYTE_W +: BYTE_W] <= reg_wdata;
      end
    end
  end

  // snapshot of the live count on a read of the low byte
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      rdata_o <= '0;
    end else if (rd_ok) begin
      if (reg_addr == '0) hold_q <= live;
      rdata_o <= src[int'(reg_addr)*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/wdalm_core.sv
module wdalm_core #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             wdmode,
  input  logic             tick_1hz,
  input  logic             tick_4khz,
  input  logic             access,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             pulse_busy,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q, seed_q;
  logic             armed_q, halt_q;
  logic             step, running;

  assign step     = wdmode ? tick_4khz : tick_1hz;
  assign running  = en && armed_q && !halt_q && !pulse_busy;
  assign expire_o = running && step && !access && (cnt_q == CNT_W'(1));
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      seed_q  <= '0;
      armed_q <= 1'b0;
      halt_q  <= 1'b0;
    end else if (load) begin
      cnt_q   <= load_val;
      seed_q  <= load_val;
      armed_q <= |load_val;
      halt_q  <= 1'b0;
    end else if (access) begin
      cnt_q  <= seed_q;
      halt_q <= 1'b0;
    end else if (expire_o) begin
      if (wdmode) begin
        cnt_q  <= '0;
        halt_q <= 1'b1;
      end else begin
        cnt_q <= seed_q;
      end
    end else if (running && step) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/wdalm_pulse.sv
module wdalm_pulse
  import wdalm_pkg::*;
#(
  parameter int TICKS = 1024,
  localparam int PW = (TICKS > 1) ? $clog2(TICKS) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic start_rst,
  input  logic start_irq,
  output logic rst_act_o,
  output logic irq_act_o,
  output logic busy_o,
  output logic done_o
);
  pulse_kind_e   kind_q;
  logic [PW-1:0] pcnt_q;

  assign busy_o    = (kind_q != PK_NONE);
  assign done_o    = busy_o && tick && (pcnt_q == PW'(TICKS - 1));
  assign rst_act_o = (kind_q == PK_RST);
  assign irq_act_o = (kind_q == PK_IRQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q <= PK_NONE;
      pcnt_q <= '0;
    end else if (done_o) begin
      kind_q <= PK_NONE;
      pcnt_q <= '0;
    end else if (busy_o) begin
      if (tick) pcnt_q <= pcnt_q + PW'(1);
    end else if (start_rst) begin
      kind_q <= PK_RST;
      pcnt_q <= '0;
    end else if (start_irq) begin
      kind_q <= PK_IRQ;
      pcnt_q <= '0;
    end
  end
endmodule

// File: rtl/wdalm_timer.sv
module wdalm_timer
  import wdalm_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int PULSE_TICKS = 1024,
  localparam int NBYTES = CNT_W / BYTE_W,
  localparam int AW = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1hz,
  input  logic              tick_4khz,
  input  logic              cfg_en,
  input  logic              cfg_wdmode,
  input  logic              cfg_steer,
  input  logic              cfg_irq_en,
  input  logic              flag_clr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [AW-1:0]     reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              flag_o,
  output logic              rst_n_o,
  output logic              rst_oe_o,
  output logic              irq_n_o,
  output logic              irq_oe_o
);
  logic             access, load;
  logic [CNT_W-1:0] load_val, cnt;
  logic             expire;
  logic             rst_act, irq_act, busy, done;
  logic             flag_q;

  wdalm_regport #(.CNT_W(CNT_W)) u_port (
    .clk(clk), .rst(rst), .blocked(rst_act),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .live(cnt), .access_o(access), .load_o(load), .load_val_o(load_val),
    .rdata_o(reg_rdata)
  );

  wdalm_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .en(cfg_en), .wdmode(cfg_wdmode),
    .tick_1hz(tick_1hz), .tick_4khz(tick_4khz),
    .access(access), .load(load), .load_val(load_val),
    .pulse_busy(busy), .cnt_o(cnt), .expire_o(expire)
  );

  wdalm_pulse #(.TICKS(PULSE_TICKS)) u_pulse (
    .clk(clk), .rst(rst), .tick(tick_4khz),
    .start_rst(expire && cfg_wdmode && !cfg_steer),
    .start_irq(expire && cfg_wdmode && cfg_steer && cfg_irq_en),
    .rst_act_o(rst_act), .irq_act_o(irq_act), .busy_o(busy), .done_o(done)
  );

  always_ff @(posedge clk) begin
    if (rst)                    flag_q <= 1'b0;
    else if (expire)            flag_q <= 1'b1;
    else if (done)              flag_q <= 1'b0;
    else if (flag_clr && !busy) flag_q <= 1'b0;
  end

  assign flag_o   = flag_q;
  assign rst_oe_o = rst_act;
  assign rst_n_o  = ~rst_act;
  assign irq_oe_o = irq_act;
  assign irq_n_o  = ~irq_act;
endmodule

// File: rtl/wdalm_chk.sv
module wdalm_chk (
  input logic clk,
  input logic rst,
  input logic tick_1hz,
  input logic tick_4khz,
  input logic flag_o,
  input logic rst_oe_o,
  input logic irq_oe_o
);
  // R6: a reset pulse only ends on a 4096 Hz tick
  a_r6_rst_hold: assert property (@(posedge clk) disable iff (rst)
    (rst_oe_o && !tick_4khz) |=> rst_oe_o);

  a_r6_rel_on_tick: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_oe_o) |-> $past(tick_4khz));

  // R7: an interrupt pulse cannot be cut short
  a_r7_irq_hold: assert property (@(posedge clk) disable iff (rst)
    (irq_oe_o && !tick_4khz) |=> irq_oe_o);

  a_r7_flag_in_pulse: assert property (@(posedge clk) disable iff (rst)
    (rst_oe_o || irq_oe_o) |-> flag_o);

  a_r6_one_pulse: assert property (@(posedge clk) disable iff (rst)
    !(rst_oe_o && irq_oe_o));

  // R4: the flag only rises on a step tick
  a_r4_flag_on_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_o) |-> $past(tick_1hz || tick_4khz));
endmodule

bind wdalm_timer wdalm_chk u_chk (
  .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .tick_4khz(tick_4khz),
  .flag_o(flag_o), .rst_oe_o(rst_oe_o), .irq_oe_o(irq_oe_o)
);

// File: tb/sim_wdalm_timer.sv
module sim_wdalm_timer;
  localparam int PT = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_1hz = 1'b0, tick_4khz = 1'b0;
  logic cfg_en = 1'b0, cfg_wdmode = 1'b0, cfg_steer = 1'b0, cfg_irq_en = 1'b0;
  logic flag_clr = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic flag_o, rst_n_o, rst_oe_o, irq_n_o, irq_oe_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  wdalm_timer #(.CNT_W(24), .PULSE_TICKS(PT)) u0 (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .tick_4khz(tick_4khz),
    .cfg_en(cfg_en), .cfg_wdmode(cfg_wdmode), .cfg_steer(cfg_steer),
    .cfg_irq_en(cfg_irq_en), .flag_clr(flag_clr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .flag_o(flag_o), .rst_n_o(rst_n_o),
    .rst_oe_o(rst_oe_o), .irq_n_o(irq_n_o), .irq_oe_o(irq_oe_o)
  );

  task automatic check(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int alarm_expect(input int v, input int n);
    return (n == v) ? v : v - n;
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 2'(a); reg_wdata = 8'(d);
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = 2'(a);
    @(negedge clk); reg_rd = 1'b0; d = int'(reg_rdata);
  endtask

  task automatic write24(input int v);
    wr(0, v & 255); wr(1, (v >> 8) & 255); wr(2, (v >> 16) & 255);
  endtask

  task automatic read24(output int v);
    int b0, b1, b2;
    rd(0, b0); rd(1, b1); rd(2, b2);
    v = b0 | (b1 << 8) | (b2 << 16);
  endtask

  task automatic t1();
    @(negedge clk); tick_1hz = 1'b1; @(negedge clk); tick_1hz = 1'b0;
  endtask

  task automatic t4(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_4khz = 1'b1; @(negedge clk); tick_4khz = 1'b0;
    end
  endtask

  task automatic clr();
    @(negedge clk); flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_up();
  end

  initial begin
    int v, n, e;
    void'($urandom(32'd1374));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(flag_o, 0, "R1 flag");
    check(rst_n_o, 1, "R1 rst_n");
    check(rst_oe_o, 0, "R1 rst_oe");
    check(irq_n_o, 1, "R1 irq_n");
    check(irq_oe_o, 0, "R1 irq_oe");
    check(reg_rdata, 0, "R1 rdata");

    // R2 staged write, commit on top byte; R10 storage mode
    cfg_en = 1'b0;
    write24(24'h123456);
    wr(0, 8'hAA); wr(1, 8'hBB);
    read24(v); check(v, 24'h123456, "R2 partial write not loaded");
    wr(2, 8'hCC);
    read24(v); check(v, 24'hCCBBAA, "R2 committed value");
    t1(); t4(5);
    read24(v); check(v, 24'hCCBBAA, "R10 no count when disabled");
    check(flag_o, 0, "R10 flag idle");

    // R11 all-zero write disables
    cfg_en = 1'b1; cfg_wdmode = 1'b1; cfg_steer = 1'b0;
    write24(0);
    t4(10); t1();
    check(flag_o, 0, "R11 no flag");
    check(rst_oe_o, 0, "R11 no pulse");
    read24(v); check(v, 0, "R11 counter idle");

    // R4 alarm mode directed
    cfg_wdmode = 1'b0;
    write24(3);
    t4(4);
    t1(); t1();
    check(flag_o, 0, "R4 no flag before zero");
    t1();
    check(flag_o, 1, "R4 flag at zero");
    t1();
    read24(v); check(v, 2, "R4 reload and continue");
    clr();
    check(flag_o, 0, "R4 flag clear");

    // R3/R4 random alarm runs
    for (int it = 0; it < 40; it++) begin
      v = int'($urandom % 40) + 1;
      n = int'($urandom % (v + 1));
      clr();
      write24(v);
      for (int k = 0; k < n; k++) begin
        t1();
        if ($urandom % 2 == 0) t4(1);
      end
      check(flag_o, (n == v) ? 1 : 0, "R4 random flag");
      read24(e); check(e, alarm_expect(v, n), "R3 random capture");
    end
    clr();

    // R5 watchdog stops at zero
    cfg_wdmode = 1'b1; cfg_steer = 1'b1; cfg_irq_en = 1'b0;
    write24(2);
    t1(); t1(); t1();
    check(flag_o, 0, "R5 1Hz ignored");
    t4(2);
    check(flag_o, 1, "R5 flag at zero");
    check(irq_oe_o, 0, "R5 no irq without enable");
    t4(3);
    read24(v); check(v, 0, "R5 stopped");
    clr();

    // R9 access restarts
    write24(5);
    t4(4);
    read24(v); check(v, 1, "R9 read before zero");
    t4(4);
    check(flag_o, 0, "R9 restarted");
    t4(1);
    check(flag_o, 1, "R9 expiry after restart");
    clr();

    // R6 reset pulse
    cfg_steer = 1'b0;
    write24(24'h000102);
    t4(24'h102);
    check(rst_oe_o, 1, "R6 pulse start");
    check(rst_n_o, 0, "R6 level low");
    check(flag_o, 1, "R6 flag");
    write24(24'h0000FF);
    t4(PT - 1);
    check(rst_oe_o, 1, "R6 still low");
    t4(1);
    check(rst_oe_o, 0, "R6 released");
    check(flag_o, 0, "R6 flag cleared");
    read24(v); check(v, 0, "R6 write blocked");

    // R7/R8 interrupt pulse
    cfg_steer = 1'b1; cfg_irq_en = 1'b1;
    write24(2);
    t4(2);
    check(irq_oe_o, 1, "R7 pulse start");
    check(irq_n_o, 0, "R7 level low");
    clr(); cfg_irq_en = 1'b0;
    check(irq_oe_o, 1, "R7 not cut by clear");
    check(flag_o, 1, "R7 flag held");
    write24(2);
    t4(3);
    read24(v); check(v, 2, "R8 no count during pulse");
    t4(PT - 4);
    check(irq_oe_o, 1, "R7 still low");
    t4(1);
    check(irq_oe_o, 0, "R7 released");
    check(flag_o, 0, "R7 flag cleared");
    cfg_irq_en = 1'b1;
    t4(1);
    check(flag_o, 0, "R8 counting after pulse");
    t4(1);
    check(flag_o, 1, "R8 expiry after pulse");
    t4(PT);
    check(irq_oe_o, 0, "R7 second pulse done");

    finish_up();
  end
endmodule